// File: doc/BRIEF.md
# Card Response Frame Receiver

This block collects a contactless card's answer after the reader has finished a frame. The card's reply carries no start marker, stop marker or length field, so the reader fixes both the timing and the bit count. On a start strobe the block takes a shared timestamp that marks where the previous frame ended. It waits a fixed turnaround of 495 timebase ticks, which is 330 us at 1.5 ticks per microsecond. It then walks through back-to-back bit periods of 150 ticks each, which is 100 us. At the end of each period it samples the demodulated bit from an external slicer and asks an external keystream generator to step once.

Frame mode is the default. In this mode every sampled bit is XORed with the current keystream bit and packed into a result word, least significant bit first. Acknowledge mode is used after a write command. In this mode the block looks for the first period in which the raw slicer bit is 1, with no keystream applied, and gives up after 60 periods. The keystream still steps once for every period it examines.

When the block finishes, it returns the tick at which the last sampled period ended, so that the next transmission can be scheduled from it. A reply of all zeros looks the same as no card being present, so the block makes no attempt to detect whether a card is there.

Top module: `card_resp_rx`

## Requirements
- R1: With timestamp T latched at an accepted start, period k (counting from 0) ends at tick T+495+150*(k+1), taken modulo 2^TS_W. The slicer bit and the keystream bit for period k are taken in the clock cycle where `nowTick` first reaches that end tick. A tick counts as reached when (nowTick - end) mod 2^TS_W is below 2^(TS_W-1), so a timestamp near the top of the range wraps correctly.
- R2: In frame mode with length L, bit i of `rxWord` (for i < L) equals the slicer bit XOR `ksBit` for period i. Bits i >= L are 0.
- R3: A frame length of 0 finishes at tick T+495 with no bit sampled. A length above MAX_BITS (32) is treated as MAX_BITS.
- R4: `ksAdvance` is a one-cycle pulse in every sampling cycle and at no other time. It pulses L times in frame mode and once per examined period in acknowledge mode.
- R5: In acknowledge mode the raw slicer bit is tested without the keystream. The first period whose bit is 1 ends the run with `ackSeen`=1, `ackTimeout`=0 and `rxWord`=0.
- R6: In acknowledge mode, if none of periods 0 to 59 shows a 1, the run ends after period 59 with `ackTimeout`=1 and `ackSeen`=0. A 1 in period 59 still counts as an acknowledge.
- R7: `ackSeen` and `ackTimeout` are never 1 together. Both are 0 after a frame-mode run.
- R8: At `done`, `frameEndOut` equals the end tick of the last sampled period, or T+495 when the length is 0.
- R9: `done` is a one-cycle pulse in the cycle after the last sampling cycle. `busy` is high from the cycle after an accepted start until `done`.
- R10: A start strobe while `busy` is high is ignored. The run in progress keeps its length, mode and timestamp, and it ends with a single `done`.
- R11: After reset, `busy`, `done`, `ksAdvance`, `ackSeen` and `ackTimeout` are 0, and `rxWord` and `frameEndOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a reception when idle |
| lenIn | input | LEN_W (6) | Number of bits to collect in frame mode |
| ackMode | input | 1 | 1 selects acknowledge hunting, 0 selects frame reception |
| frameEndIn | input | TS_W (16) | Tick at which the previous frame ended |
| nowTick | input | TS_W (16) | Free-running timebase |
| slicerBit | input | 1 | Demodulated bit for the period now ending |
| ksBit | input | 1 | Current keystream bit |
| ksAdvance | output | 1 | Step the keystream generator |
| busy | output | 1 | A reception is in progress |
| done | output | 1 | Result valid, one cycle |
| rxWord | output | MAX_BITS (32) | De-whitened received bits, LSB first |
| ackSeen | output | 1 | Acknowledge found |
| ackTimeout | output | 1 | No acknowledge within the limit |
| frameEndOut | output | TS_W (16) | End tick of the last sampled period |

## Verification
A wrong deadline or a miscounted period moves the tick at which `done` rises, and it also changes `frameEndOut`. The bench compares `nowTick` at `done` with the predicted end tick, so an error of a single tick shows on the first run. A misaligned bit index or a keystream bit applied in the wrong place corrupts `rxWord` at the first `done`. A wrong stepping count shows as a mismatch in the number of `ksAdvance` pulses the bench counts. A termination fault in acknowledge mode flips `ackSeen` or `ackTimeout` for the patterns at period 0, period 59 and just beyond the limit.

// File: rtl/card_resp_rx_pkg.sv
package card_resp_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TURN    = 2'd1,
    ST_COLLECT = 2'd2
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBase;     // latch timestamp + turnaround, clear index and word
    logic stepDeadline; // move deadline one bit period on
    logic markEnd;      // record current deadline as frame end
    logic takeBit;      // store de-whitened bit at current index
    logic countUp;      // advance bit index
  } rxStrobe_t;

endpackage

// File: rtl/card_resp_rx_dp.sv
module card_resp_rx_dp
  import card_resp_rx_pkg::*;
#(
  parameter int TS_W         = 16,
  parameter int MAX_BITS     = 32,
  parameter int TURN_TICKS   = 495,
  parameter int PERIOD_TICKS = 150,
  parameter int IDX_W        = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           strobe,
  input  logic [TS_W-1:0]     frameEndIn,
  input  logic [TS_W-1:0]     nowTick,
  input  logic                slicerBit,
  input  logic                ksBit,
  output logic                reached,
  output logic [IDX_W-1:0]    idx,
  output logic [MAX_BITS-1:0] rxWord,
  output logic [TS_W-1:0]     frameEndOut
);

  localparam logic [TS_W-1:0] TURN_C   = TS_W'(TURN_TICKS);
  localparam logic [TS_W-1:0] PERIOD_C = TS_W'(PERIOD_TICKS);

  logic [TS_W-1:0] deadline;
  logic [TS_W-1:0] gap;

  // wrap-safe "now >= deadline"
  assign gap     = nowTick - deadline;
  assign reached = ~gap[TS_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deadline    <= '0;
      frameEndOut <= '0;
      idx         <= '0;
    end else if (strobe.loadBase) begin
      deadline <= frameEndIn + TURN_C;
      idx      <= '0;
    end else begin
      if (strobe.stepDeadline) deadline <= deadline + PERIOD_C;
      if (strobe.markEnd)      frameEndOut <= deadline;
      if (strobe.countUp)      idx <= idx + 1'b1;
    end
  end

  // result word: one write port per bit position
  for (genvar b = 0; b < MAX_BITS; b++) begin : g_wordBit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rxWord[b] <= 1'b0;
      else if (strobe.loadBase)
        rxWord[b] <= 1'b0;
      else if (strobe.takeBit && (idx == IDX_W'(b)))
        rxWord[b] <= slicerBit ^ ksBit;
    end
  end

  // R2: a bit is only stored inside the word
  assert_bit_in_range_R2 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeBit |-> (idx < IDX_W'(MAX_BITS)));

  // R1: the end of a period is only recorded once its deadline is reached
  assert_end_on_deadline_R1 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.markEnd |-> reached);

endmodule

// File: rtl/card_resp_rx_ctrl.sv
module card_resp_rx_ctrl
  import card_resp_rx_pkg::*;
#(
  parameter int LEN_W     = 6,
  parameter int IDX_W     = 6,
  parameter int MAX_BITS  = 32,
  parameter int ACK_LIMIT = 60
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] lenIn,
  input  logic             ackMode,
  input  logic             slicerBit,
  input  logic             reached,
  input  logic [IDX_W-1:0] idx,
  output rxStrobe_t        strobe,
  output logic             ksAdvance,
  output logic             busy,
  output logic             done,
  output logic             ackSeen,
  output logic             ackTimeout
);

  rxState_t         state;
  logic             modeAck;
  logic             lenZero;
  logic [IDX_W-1:0] lastIdx;
  logic [LEN_W-1:0] lenClamp;
  logic             finish;

  assign lenClamp = (lenIn > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : lenIn;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strobe    = '0;
    finish    = 1'b0;
    ksAdvance = 1'b0;
    case (state)
      ST_IDLE: strobe.loadBase = start;
      ST_TURN: begin
        if (reached) begin
          strobe.stepDeadline = 1'b1;
          if (lenZero) begin
            strobe.markEnd = 1'b1;
            finish         = 1'b1;
          end
        end
      end
      ST_COLLECT: begin
        if (reached) begin
          ksAdvance           = 1'b1;
          strobe.stepDeadline = 1'b1;
          strobe.markEnd      = 1'b1;
          strobe.countUp      = 1'b1;
          strobe.takeBit      = ~modeAck;
          finish              = (idx == lastIdx) || (modeAck && slicerBit);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      modeAck    <= 1'b0;
      lenZero    <= 1'b0;
      lastIdx    <= '0;
      done       <= 1'b0;
      ackSeen    <= 1'b0;
      ackTimeout <= 1'b0;
    end else begin
      done <= finish;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_TURN;
            modeAck    <= ackMode;
            lenZero    <= ~ackMode && (lenClamp == '0);
            lastIdx    <= ackMode ? IDX_W'(ACK_LIMIT - 1) : IDX_W'(lenClamp) - 1'b1;
            ackSeen    <= 1'b0;
            ackTimeout <= 1'b0;
          end
        end
        ST_TURN: begin
          if (finish)       state <= ST_IDLE;
          else if (reached) state <= ST_COLLECT;
        end
        ST_COLLECT: begin
          if (finish) begin
            state <= ST_IDLE;
            if (modeAck) begin
              ackSeen    <= slicerBit;
              ackTimeout <= ~slicerBit;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9 : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: acknowledge outcomes exclude each other
  assert_flags_exclusive_R7 : assert property (@(posedge clk) disable iff (!rstN)
    !(ackSeen && ackTimeout));

  // R10: a start during a run leaves the latched setup alone
  assert_start_ignored_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> ($stable(modeAck) && $stable(lastIdx) && $stable(lenZero)));

  // R5: a raw 1 in acknowledge mode ends the run as found
  assert_ack_raw_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COLLECT && reached && modeAck && slicerBit) |=> (done && ackSeen));

endmodule

// File: rtl/card_resp_rx.sv
module card_resp_rx
  import card_resp_rx_pkg::*;
#(
  parameter int TS_W         = 16,
  parameter int MAX_BITS     = 32,
  parameter int TURN_TICKS   = 495,
  parameter int PERIOD_TICKS = 150,
  parameter int ACK_LIMIT    = 60,
  parameter int LEN_W        = $clog2(MAX_BITS + 1),
  localparam int IDX_LIM     = (MAX_BITS > ACK_LIMIT) ? MAX_BITS : ACK_LIMIT,
  localparam int IDX_W       = $clog2(IDX_LIM + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [LEN_W-1:0]    lenIn,
  input  logic                ackMode,
  input  logic [TS_W-1:0]     frameEndIn,
  input  logic [TS_W-1:0]     nowTick,
  input  logic                slicerBit,
  input  logic                ksBit,
  output logic                ksAdvance,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] rxWord,
  output logic                ackSeen,
  output logic                ackTimeout,
  output logic [TS_W-1:0]     frameEndOut
);

  rxStrobe_t        strobe;
  logic             reached;
  logic [IDX_W-1:0] idx;

  card_resp_rx_ctrl #(
    .LEN_W(LEN_W), .IDX_W(IDX_W), .MAX_BITS(MAX_BITS), .ACK_LIMIT(ACK_LIMIT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .lenIn(lenIn), .ackMode(ackMode),
    .slicerBit(slicerBit), .reached(reached), .idx(idx), .strobe(strobe),
    .ksAdvance(ksAdvance), .busy(busy), .done(done),
    .ackSeen(ackSeen), .ackTimeout(ackTimeout)
  );

  card_resp_rx_dp #(
    .TS_W(TS_W), .MAX_BITS(MAX_BITS), .TURN_TICKS(TURN_TICKS),
    .PERIOD_TICKS(PERIOD_TICKS), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameEndIn(frameEndIn),
    .nowTick(nowTick), .slicerBit(slicerBit), .ksBit(ksBit),
    .reached(reached), .idx(idx), .rxWord(rxWord), .frameEndOut(frameEndOut)
  );

  // R4: the keystream only steps inside a run
  assert_adv_in_run_R4 : assert property (@(posedge clk) disable iff (!rstN)
    ksAdvance |-> busy);

endmodule

// File: tb/card_resp_rx_tb_top.sv
module card_resp_rx_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  lenIn = '0;
  logic        ackMode = 1'b0;
  logic [15:0] frameEndIn = '0;
  logic [15:0] nowTick = '0;
  logic        slicerBit = 1'b0;
  logic        ksBit;
  logic        ksAdvance, busy, done, ackSeen, ackTimeout;
  logic [31:0] rxWord;
  logic [15:0] frameEndOut;

  card_resp_rx dut_i (
    .clk(clk), .rstN(rstN), .start(start), .lenIn(lenIn), .ackMode(ackMode),
    .frameEndIn(frameEndIn), .nowTick(nowTick), .slicerBit(slicerBit), .ksBit(ksBit),
    .ksAdvance(ksAdvance), .busy(busy), .done(done), .rxWord(rxWord),
    .ackSeen(ackSeen), .ackTimeout(ackTimeout), .frameEndOut(frameEndOut)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int doneCount = 0;
  int advCount = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] word;
    bit          seen;
    bit          tmo;
    logic [15:0] endTs;
    int          advEnd;
  } exp_t;
  exp_t q[$];

  logic [15:0] curBase = '0;
  logic [63:0] curPattern = '0;
  logic [15:0] ksState = 16'hACE1;
  bit          jumpReq = 0;
  logic [15:0] jumpVal = '0;

  function automatic logic [15:0] ksStep(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic slicerFor(logic [15:0] t);
    logic [15:0] off;
    off = t - curBase - 16'd496;
    if (off < 16'd9600) return curPattern[off / 16'd150];
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // timebase and slicer
  initial begin
    ksBit = ksState[0];
    forever begin
      @(posedge clk);
      #1;
      if (jumpReq) begin
        nowTick = jumpVal;
        jumpReq = 0;
      end else begin
        nowTick = nowTick + 16'd1;
      end
      slicerBit = slicerFor(nowTick);
    end
  end

  // keystream model
  initial begin
    forever begin
      logic adv;
      @(negedge clk);
      adv = ksAdvance;
      @(posedge clk);
      #2;
      if (adv) begin
        ksState = ksStep(ksState);
        ksBit   = ksState[0];
        advCount++;
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        doneCount++;
        if (q.size() == 0) begin
          chk(0, "R10 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rxWord == e.word, "R2/R5 rxWord", rxWord, e.word);
          chk(ackSeen == e.seen, "R5/R7 ackSeen", ackSeen, e.seen);
          chk(ackTimeout == e.tmo, "R6/R7 ackTimeout", ackTimeout, e.tmo);
          chk(frameEndOut == e.endTs, "R8 frameEndOut", frameEndOut, e.endTs);
          chk(nowTick == e.endTs + 16'd1, "R1/R9 done timing", nowTick, e.endTs + 16'd1);
          chk(advCount == e.advEnd, "R4 advance count", advCount, e.advEnd);
          chk(!busy, "R9 busy low at done", busy, 0);
        end
      end
    end
  end

  // driver: predict, push, start
  task automatic launch(input int lenv, input bit mode, input logic [63:0] pat, input int feOff);
    exp_t e;
    logic [15:0] k;
    logic [15:0] fe;
    int n;
    int effLen;
    bit found;
    @(negedge clk);
    fe = nowTick + 16'(feOff);
    k = ksState;
    e.word = '0;
    e.seen = 0;
    e.tmo = 0;
    n = 0;
    if (!mode) begin
      effLen = (lenv > 32) ? 32 : lenv;
      for (int i = 0; i < effLen; i++) begin
        e.word[i] = pat[i] ^ k[0];
        k = ksStep(k);
      end
      n = effLen;
    end else begin
      found = 0;
      for (int i = 0; i < 60; i++) begin
        if (!found) begin
          n++;
          if (pat[i]) found = 1;
        end
      end
      e.seen = found;
      e.tmo = !found;
    end
    e.endTs = fe + 16'd495 + 16'(150 * n);
    e.advEnd = advCount + n;
    q.push_back(e);
    curBase = fe;
    curPattern = pat;
    start = 1'b1;
    lenIn = 6'(lenv);
    ackMode = mode;
    frameEndIn = fe;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9 busy after start", busy, 1);
  endtask

  task automatic waitIdle();
    while (q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    int dc;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !ksAdvance, "R11 control outputs", {busy, done, ksAdvance}, 0);
    chk(rxWord == 0 && !ackSeen && !ackTimeout, "R11 result outputs", rxWord, 0);
    chk(frameEndOut == 0, "R11 frameEndOut", frameEndOut, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    launch(8, 0, 64'hA5, 40);                 waitIdle();  // R2 short frame
    launch(32, 0, 64'hDEADBEEF, 5);           waitIdle();  // R2 full word
    launch(1, 0, 64'h1, 0);                   waitIdle();  // R2 single bit
    launch(0, 0, 64'hFFFF, 20);               waitIdle();  // R3 zero length
    launch(40, 0, 64'hFFFF_FFFF_FFFF_FFFF, 3);waitIdle();  // R3 clamp
    launch(0, 1, 64'h8, 10);                  waitIdle();  // R5 ack at period 3
    launch(0, 1, 64'h1, 10);                  waitIdle();  // R5 ack at period 0
    launch(0, 1, 64'h0, 10);                  waitIdle();  // R6 timeout, raw test
    launch(0, 1, 64'h1 << 59, 10);            waitIdle();  // R6 last period ack
    launch(0, 1, 64'h1 << 60, 10);            waitIdle();  // R6 beyond limit

    // R1 timestamp wrap
    @(negedge clk);
    jumpVal = 16'd65300;
    jumpReq = 1;
    repeat (3) @(negedge clk);
    launch(16, 0, 64'h3C5A, 5);               waitIdle();

    // R10 start while busy ignored
    dc = doneCount;
    launch(8, 0, 64'h96, 10);
    repeat (200) @(negedge clk);
    start = 1'b1; lenIn = 6'd2; ackMode = 1'b1; frameEndIn = nowTick;
    @(negedge clk);
    start = 1'b0;
    waitIdle();
    repeat (1500) @(negedge clk);
    chk(doneCount == dc + 1, "R10 single done", doneCount, dc + 1);
    chk(!busy, "R10 idle afterwards", busy, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule